// File: doc/BRIEF.md
# CPU Error Status Register with Kernel Stack Limit Check

This block keeps a small sticky record of why the processor last aborted or trapped on an error. The core and the memory system report each cause as a one-cycle strobe: a halt executed outside kernel mode, an odd-address access, an access to memory that does not exist, and a bus timeout. Each cause sets its own bit, and the bit stays set until software writes the register. Any write clears the register, whatever the data.

The block also checks kernel stack pushes. When a push is valid, its target address is compared against two limits. A target just below the normal limit is a yellow-zone push: the push completes, the yellow bit is set and a trap is requested one cycle later. A target below the lower limit is a red-zone push: the red bit is set and an abort is requested in the same cycle. A fault reported during a push is fatal. The fault is escalated to a red abort, and its cause bit is recorded along with the red bit. A memory-management abort during a push is recorded as red plus odd-address.

Top module: `cpu_err_reg`

## Requirements
- R1: After reset `regRdData` reads 0, and `yellowTrap` and `redAbort` are low.
- R2: Any cycle with `regWrEn` high clears all bits at the next clock edge, whatever the value on `regWrData`.
- R3: Cause bit positions in `regRdData` are:
  - halt outside kernel mode: bit 7
  - odd address: bit 6
  - non-existent memory: bit 5
  - bus timeout: bit 4
  - yellow zone: bit 3
  - red zone: bit 2

  Each of `evHalt`, `evOdd`, `evNxm` and `evTmo` sets its bit at the next edge. Bits 15:8 and 1:0 always read 0.
- R4: Bits are sticky. A cycle without a write only adds bits, and causes from different cycles accumulate.
- R5: A push (`pushValid`) with `pushAddr` below 0340 octal drives `redAbort` high in the same cycle and sets bit 2.
- R6: A fault-free push with `pushAddr` from 0340 through 0377 octal does three things:
  - sets bit 3,
  - pulses `yellowTrap` high for exactly the one cycle after the push,
  - leaves `redAbort` low.
- R7: A fault-free push with `pushAddr` at 0400 octal or above sets no bit and raises neither output.
- R8: Any of `evOdd`, `evNxm`, `evTmo` or `evMmu` in the same cycle as a push does three things:
  - raises `redAbort` in that cycle,
  - sets bit 2 together with the cause bit,
  - sets no yellow bit and raises no `yellowTrap`, whatever the address.
- R9: `evMmu` during a push sets bits 2 and 6. `evMmu` without a push has no effect.
- R10: A cause that arrives in the same cycle as a write is recorded after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe; any write clears |
| regWrData | input | 16 | Write data, ignored |
| regRdData | output | 16 | Register read value |
| evHalt | input | 1 | Halt executed outside kernel mode |
| evOdd | input | 1 | Odd-address abort |
| evNxm | input | 1 | Non-existent memory abort |
| evTmo | input | 1 | Bus timeout abort |
| evMmu | input | 1 | Memory-management abort |
| pushValid | input | 1 | Kernel stack push in this cycle |
| pushAddr | input | 16 | Target address of the push |
| yellowTrap | output | 1 | Yellow-zone trap request, one cycle after the push |
| redAbort | output | 1 | Red-zone or fatal stack abort, same cycle as the push |

## Verification
The assertions check the following on every cycle:
- the unused bits stay zero;
- a write clears the register;
- bits only accumulate between writes;
- every red-zone push aborts;
- every fault-free yellow-zone push traps one cycle later;
- an abort is never followed by a trap.

Only the bench scenarios show the full mapping from each cause, alone or combined with a push, to the right bit pattern. They also show the exact zone boundaries at 0336, 0340, 0376 and 0400 octal, the ignored data on writes, and the recording of a cause that coincides with a clear.

// File: rtl/cpu_err_pkg.sv
package cpu_err_pkg;

  // Bit positions of the causes in the read word
  localparam int HALT_BIT = 7;
  localparam int ODD_BIT  = 6;
  localparam int NXM_BIT  = 5;
  localparam int TMO_BIT  = 4;
  localparam int YEL_BIT  = 3;
  localparam int RED_BIT  = 2;

  // Number of stored cause bits
  localparam int NUM_CAUSE = 6;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic clr;
    logic halt;
    logic odd;
    logic nxm;
    logic tmo;
    logic yel;
    logic red;
  } errCmd_t;

endpackage

// File: rtl/cpu_err_ctrl.sv
module cpu_err_ctrl
  import cpu_err_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int RED_LIMIT = 'o340,
  parameter int YEL_LIMIT = 'o400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              evHalt,
  input  logic              evOdd,
  input  logic              evNxm,
  input  logic              evTmo,
  input  logic              evMmu,
  input  logic              pushValid,
  input  logic [ADDR_W-1:0] pushAddr,
  output errCmd_t           cmd,
  output logic              yellowTrap,
  output logic              redAbort
);

  localparam logic [ADDR_W-1:0] RED_A = ADDR_W'(RED_LIMIT);
  localparam logic [ADDR_W-1:0] YEL_A = ADDR_W'(YEL_LIMIT);

  logic belowRed;
  logic belowYel;
  logic pushFault;
  logic redZone;
  logic yelZone;
  logic trapQ;

  // Zone classification of the push target
  assign belowRed  = pushAddr < RED_A;
  assign belowYel  = pushAddr < YEL_A;
  assign pushFault = pushValid && (evOdd || evNxm || evTmo || evMmu);
  assign redZone   = pushValid && belowRed;
  assign yelZone   = pushValid && !belowRed && belowYel && !pushFault;

  always_comb begin
    cmd      = '0;
    cmd.clr  = regWrEn;
    cmd.halt = evHalt;
    cmd.odd  = evOdd || (pushValid && evMmu);
    cmd.nxm  = evNxm;
    cmd.tmo  = evTmo;
    cmd.red  = redZone || pushFault;
    cmd.yel  = yelZone;
  end

  assign redAbort = cmd.red;

  // Yellow trap is requested after the push completes
  always_ff @(posedge clk) begin
    if (!rstN) trapQ <= 1'b0;
    else       trapQ <= yelZone;
  end

  assign yellowTrap = trapQ;

endmodule

// File: rtl/cpu_err_dp.sv
module cpu_err_dp
  import cpu_err_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  errCmd_t           cmd,
  output logic [DATA_W-1:0] rdData
);

  localparam int POS_W = $clog2(DATA_W);

  // Read-word position of each stored cause, index order of errQ
  localparam logic [NUM_CAUSE*8-1:0] POS_TAB = {
    8'(HALT_BIT), 8'(ODD_BIT), 8'(NXM_BIT),
    8'(TMO_BIT),  8'(YEL_BIT), 8'(RED_BIT)
  };

  logic [NUM_CAUSE-1:0] errQ;
  logic [NUM_CAUSE-1:0] setVec;

  assign setVec = {cmd.halt, cmd.odd, cmd.nxm, cmd.tmo, cmd.yel, cmd.red};

  // Clear on write, then OR in this cycle's causes
  always_ff @(posedge clk) begin
    if (!rstN) errQ <= '0;
    else       errQ <= (cmd.clr ? '0 : errQ) | setVec;
  end

  // Scatter the stored causes onto their read positions
  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CAUSE; i++) begin
      rdData[POS_TAB[i*8 +: POS_W]] = errQ[i];
    end
  end

endmodule

// File: rtl/cpu_err_reg.sv
module cpu_err_reg
  import cpu_err_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 16,
  parameter int RED_LIMIT = 'o340,
  parameter int YEL_LIMIT = 'o400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              evHalt,
  input  logic              evOdd,
  input  logic              evNxm,
  input  logic              evTmo,
  input  logic              evMmu,
  input  logic              pushValid,
  input  logic [ADDR_W-1:0] pushAddr,
  output logic              yellowTrap,
  output logic              redAbort
);

  errCmd_t cmd;

  // Write data carries no meaning: any write clears
  logic unusedWrData;
  assign unusedWrData = ^regWrData;

  cpu_err_ctrl #(
    .ADDR_W(ADDR_W),
    .RED_LIMIT(RED_LIMIT),
    .YEL_LIMIT(YEL_LIMIT)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .regWrEn(regWrEn),
    .evHalt(evHalt),
    .evOdd(evOdd),
    .evNxm(evNxm),
    .evTmo(evTmo),
    .evMmu(evMmu),
    .pushValid(pushValid),
    .pushAddr(pushAddr),
    .cmd(cmd),
    .yellowTrap(yellowTrap),
    .redAbort(redAbort)
  );

  cpu_err_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .cmd(cmd),
    .rdData(regRdData)
  );

endmodule

// File: rtl/cpu_err_chk.sv
module cpu_err_chk
  import cpu_err_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 16,
  parameter int RED_LIMIT = 'o340,
  parameter int YEL_LIMIT = 'o400
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regRdData,
  input logic              evHalt,
  input logic              evOdd,
  input logic              evNxm,
  input logic              evTmo,
  input logic              evMmu,
  input logic              pushValid,
  input logic [ADDR_W-1:0] pushAddr,
  input logic              yellowTrap,
  input logic              redAbort
);

  localparam logic [ADDR_W-1:0] RED_A = ADDR_W'(RED_LIMIT);
  localparam logic [ADDR_W-1:0] YEL_A = ADDR_W'(YEL_LIMIT);

  logic [DATA_W-1:0] usedMask;
  logic              anyFault;

  always_comb begin
    usedMask = '0;
    usedMask[HALT_BIT] = 1'b1;
    usedMask[ODD_BIT]  = 1'b1;
    usedMask[NXM_BIT]  = 1'b1;
    usedMask[TMO_BIT]  = 1'b1;
    usedMask[YEL_BIT]  = 1'b1;
    usedMask[RED_BIT]  = 1'b1;
  end

  assign anyFault = evOdd || evNxm || evTmo || evMmu;

  // R3: unused positions read zero
  p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & ~usedMask) == '0);

  // R2: a write with no cause pending clears everything
  p_write_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !evHalt && !anyFault && !pushValid) |=> (regRdData == '0));

  // R4: without a write, bits never drop
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ((regRdData & $past(regRdData)) == $past(regRdData)));

  // R5: red-zone push aborts in the same cycle
  p_red_abort_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && pushAddr < RED_A) |-> redAbort);

  // R5: red-zone push records the red bit
  p_red_bit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && pushAddr < RED_A) |=> regRdData[RED_BIT]);

  // R6: fault-free yellow-zone push traps one cycle later
  p_yel_trap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && pushAddr >= RED_A && pushAddr < YEL_A && !anyFault)
      |=> yellowTrap);

  // R8: an abort is never followed by a trap
  p_abort_no_trap_r8: assert property (@(posedge clk) disable iff (!rstN)
    redAbort |=> !yellowTrap);

  // R8: fault during a push escalates to abort
  p_fault_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && anyFault) |-> redAbort);

endmodule

bind cpu_err_reg cpu_err_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .RED_LIMIT(RED_LIMIT),
  .YEL_LIMIT(YEL_LIMIT)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .regWrEn(regWrEn),
  .regRdData(regRdData),
  .evHalt(evHalt),
  .evOdd(evOdd),
  .evNxm(evNxm),
  .evTmo(evTmo),
  .evMmu(evMmu),
  .pushValid(pushValid),
  .pushAddr(pushAddr),
  .yellowTrap(yellowTrap),
  .redAbort(redAbort)
);

// File: tb/cpu_err_reg_tb.sv
module cpu_err_reg_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        evHalt = 1'b0;
  logic        evOdd = 1'b0;
  logic        evNxm = 1'b0;
  logic        evTmo = 1'b0;
  logic        evMmu = 1'b0;
  logic        pushValid = 1'b0;
  logic [15:0] pushAddr = '0;
  logic        yellowTrap;
  logic        redAbort;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cpu_err_reg u_dut (
    .clk(clk),
    .rstN(rstN),
    .regWrEn(regWrEn),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .evHalt(evHalt),
    .evOdd(evOdd),
    .evNxm(evNxm),
    .evTmo(evTmo),
    .evMmu(evMmu),
    .pushValid(pushValid),
    .pushAddr(pushAddr),
    .yellowTrap(yellowTrap),
    .redAbort(redAbort)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp,
                       input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Write with arbitrary data, expect a clean register afterwards (R2)
  task automatic clearReg(input logic [15:0] data);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
    check(regRdData, 16'h0, "R2 write clears");
  endtask

  // One stimulus: ev = {halt, mmu, tmo, nxm, odd}
  task automatic applyOne(input logic push, input logic [15:0] addr,
                          input logic [4:0] ev);
    logic fault, red, yel;
    logic [15:0] expV;
    fault = push && (ev[3:0] != 4'b0);
    red   = (push && addr < 16'o340) || fault;
    yel   = push && addr >= 16'o340 && addr < 16'o400 && !fault;
    expV  = '0;
    expV[7] = ev[4];
    expV[6] = ev[0] || (push && ev[3]);
    expV[5] = ev[1];
    expV[4] = ev[2];
    expV[3] = yel;
    expV[2] = red;
    @(negedge clk);
    pushValid = push;
    pushAddr  = addr;
    evOdd  = ev[0];
    evNxm  = ev[1];
    evTmo  = ev[2];
    evMmu  = ev[3];
    evHalt = ev[4];
    #1;
    check({15'b0, redAbort}, {15'b0, red}, "R5/R8 redAbort same cycle");
    @(negedge clk);
    pushValid = 1'b0;
    {evOdd, evNxm, evTmo, evMmu, evHalt} = '0;
    check({15'b0, yellowTrap}, {15'b0, yel}, "R6 yellowTrap next cycle");
    check(regRdData, expV, "R3/R5/R6/R7/R8/R9 cause bits");
    #1;
    check({15'b0, redAbort}, 16'h0, "R5 abort only with push");
    @(negedge clk);
    check({15'b0, yellowTrap}, 16'h0, "R6 trap single cycle");
    clearReg(addr ^ {11'b0, ev});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(regRdData, 16'h0, "R1 reset read");
    check({14'b0, yellowTrap, redAbort}, 16'h0, "R1 reset outputs");
    rstN = 1'b1;
    @(negedge clk);
    check(regRdData, 16'h0, "R1 after reset");

    // Address sweep, fault-free pushes (R5, R6, R7)
    for (int a = 0; a <= 'o600; a += 2) applyOne(1'b1, 16'(a), 5'b0);
    // Causes alone and combined with pushes in each zone (R3, R8, R9)
    for (int e = 0; e < 32; e++) begin
      applyOne(1'b0, 16'o1000, 5'(e));
      applyOne(1'b1, 16'o100, 5'(e));
      applyOne(1'b1, 16'o350, 5'(e));
      applyOne(1'b1, 16'o4000, 5'(e));
    end

    // R4: causes from different cycles accumulate
    @(negedge clk); evOdd = 1'b1;
    @(negedge clk); evOdd = 1'b0; evNxm = 1'b1;
    @(negedge clk); evNxm = 1'b0; evHalt = 1'b1;
    @(negedge clk); evHalt = 1'b0;
    check(regRdData, 16'h00E0, "R4 sticky accumulate");
    clearReg(16'hFFFF);
    @(negedge clk); evTmo = 1'b1;
    @(negedge clk); evTmo = 1'b0;
    clearReg(16'h0004);
    @(negedge clk); evOdd = 1'b1;
    @(negedge clk); evOdd = 1'b0;
    clearReg(~regRdData);

    // R10: cause in the same cycle as a write survives
    @(negedge clk); evNxm = 1'b1;
    @(negedge clk); evNxm = 1'b0;
    regWrEn = 1'b1; evHalt = 1'b1;
    @(negedge clk); regWrEn = 1'b0; evHalt = 1'b0;
    check(regRdData, 16'h0080, "R10 cause with write");
    clearReg(16'h1234);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule